// File: doc/BRIEF.md
# Scan Test Sequencer with Per-Cycle Toggle Accounting

This block runs the scan test of one core through a fixed set of parallel wrapper chains whose lengths may differ. For each pattern it shifts a stimulus into every chain, spends exactly one cycle on capture, and then shifts the captured response out while the next stimulus shifts in. After the last pattern it unloads the final response without taking further stream data. Stimulus and expected-response bits arrive one beat per shift cycle on a valid/ready stream, with one stimulus bit and one response bit per chain in each beat.

The block keeps an exact copy of every chain flip-flop. On every cycle it reports how many of those flip-flops change value at the coming clock edge. It also keeps a running total and the largest single-cycle count seen. It compares each cycle's count against a budget that can be changed at any time, and latches a sticky flag together with the index of the first cycle that went over the budget. A test controller can then judge whether running this core next to others would exceed a power limit on any cycle, rather than relying on one worst-case figure.

Top module: `scan_tog_seq`

## Requirements
- R1: Let L be the longest chain length and p the pattern count. A run is L accepted shift beats, then one capture cycle, repeated p times, followed by L unload shifts that take no stream data. `stim_ready` is high only in load/shift cycles and low during capture and unload. Without stalls, the run has exactly (L+1)·p + L active cycles.
- R2: Each accepted beat moves every chain one position toward its scan-out end and inserts the new bit at position 0. The first real stimulus bit of a chain ends up at that chain's scan-out end (position length−1).
- R3: A chain of length Lk takes its stream bit only on beats j ≥ L−Lk, counting beats 0..L−1 within a load. On earlier beats it loads a zero filler, whatever the stream carries.
- R4: During a shift cycle, `step_tog` equals the number of chain flip-flops, summed over all chains, whose value changes at the next edge. A 0→1 change and a 1→0 change each count as one.
- R5: During the capture cycle, `step_tog` equals the number of positions where the loaded stimulus differs from its expected response. After that edge the chains hold the expected response.
- R6: In a load/shift cycle with `stim_valid` low, nothing shifts, `step_tog` is 0 and the cycle is not counted as a test step.
- R7: `tog_total` is the 32-bit sum of `step_tog` over the run, and `tog_peak` is the largest `step_tog` of the run. Both are cleared when a start is accepted.
- R8: If any active cycle has `step_tog` > `budget`, `over_budget` is set. It stays set until the next accepted start. `over_idx` holds the 0-based index of the first such active step, where stall cycles are not counted.
- R9: A `start` seen while idle latches `num_pat`, with 0 treated as 1, and begins a run. A `start` seen while busy is ignored. `done` is a one-cycle pulse in the first idle cycle after the last unload shift, and `busy` is low while `done` is high.
- R10: After reset all chain flip-flops are zero. `busy`, `done`, `stim_ready`, `step_tog`, `tog_total`, `tog_peak` and `over_budget` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a run (accepted only when idle) |
| num_pat | input | PCW | Pattern count for the run |
| budget | input | TOGW | Per-cycle toggle budget |
| stim_valid | input | 1 | Stream beat valid |
| stim_ready | output | 1 | Block accepts a beat this cycle |
| stim_bits | input | NCH | Stimulus bit per chain |
| resp_bits | input | NCH | Expected response bit per chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| step_tog | output | TOGW | Flip-flop toggles at the coming edge |
| tog_total | output | 32 | Running toggle sum of the run |
| tog_peak | output | TOGW | Largest per-cycle count of the run |
| over_budget | output | 1 | Sticky budget-exceeded flag |
| over_idx | output | 32 | Step index of the first budget breach |

## Verification
Two things can fall on one cycle: an accepted shift beat, and a second `start` that arrives while a run is busy. The bench pulses `start` with a different pattern count in the middle of the first load, and it does so while stalling the stream every few beats. It judges the outcome by comparing each later `step_tog` with its behavioural model and the final active-cycle count with (L+1)·p + L. If the second start had been taken, the chain contents and the capture mismatch counts would diverge from the model. The same runs also check filler masking, because the bench drives random values on filler beats.

// File: rtl/scan_tog_pkg.sv
package scan_tog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2,
    ST_FLUSH = 2'd3
  } seq_st_e;

  // Number of set bits in a 64-bit word.
  function automatic int ones64(input logic [63:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  // Budget test used by the statistics unit.
  function automatic logic exceeds(input int tog, input int lim);
    return tog > lim;
  endfunction
endpackage

// File: rtl/scan_chain_bank.sv
module scan_chain_bank
  import scan_tog_pkg::*;
#(
  parameter int NCH  = 3,
  parameter logic [NCH*8-1:0] LENS = 24'h03_06_04,
  parameter int MAXL = 6,
  parameter int TOGW = 5,
  parameter int BW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            capt_en,
  input  logic            from_stream,
  input  logic [BW-1:0]   beat,
  input  logic [NCH-1:0]  stim_bits,
  input  logic [NCH-1:0]  resp_bits,
  output logic [TOGW-1:0] tog
);
  logic [TOGW-1:0] tog_ch [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_chain
    localparam int LK = int'(LENS[k*8 +: 8]);
    localparam logic [MAXL-1:0] MASK = {MAXL{1'b1}} >> (MAXL - LK);
    logic [MAXL-1:0] ch, rs, ch_nxt, rs_nxt;
    logic real_beat, sbit, rbit;

    assign real_beat = beat >= BW'(MAXL - LK);
    assign sbit      = from_stream & real_beat & stim_bits[k];
    assign rbit      = real_beat & resp_bits[k];
    assign ch_nxt    = {ch[MAXL-2:0], sbit} & MASK;
    assign rs_nxt    = {rs[MAXL-2:0], rbit} & MASK;
    assign tog_ch[k] = capt_en ? TOGW'(ones64(64'(ch ^ rs)))
                               : TOGW'(ones64(64'(ch ^ ch_nxt)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch <= '0;
        rs <= '0;
      end else begin
        if (shift_en)     ch <= ch_nxt;
        else if (capt_en) ch <= rs;
        if (shift_en && from_stream) rs <= rs_nxt;
      end
    end
  end

  always_comb begin
    tog = '0;
    for (int k = 0; k < NCH; k++) tog = tog + tog_ch[k];
  end
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_tog_pkg::*;
#(
  parameter int MAXL = 6,
  parameter int PCW  = 8,
  parameter int BW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [PCW-1:0] num_pat,
  input  logic           stim_valid,
  output logic           stim_ready,
  output logic           shift_en,
  output logic           capt_en,
  output logic           from_stream,
  output logic [BW-1:0]  beat,
  output logic           start_acc,
  output logic           busy,
  output logic           done
);
  seq_st_e        st;
  logic [PCW-1:0] pat_q, npat_q;
  logic           last_beat;

  assign last_beat   = beat == BW'(MAXL - 1);
  assign stim_ready  = st == ST_SHIFT;
  assign from_stream = st == ST_SHIFT;
  assign shift_en    = (st == ST_SHIFT && stim_valid) || st == ST_FLUSH;
  assign capt_en     = st == ST_CAPT;
  assign start_acc   = st == ST_IDLE && start;
  assign busy        = st != ST_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      beat   <= '0;
      pat_q  <= '0;
      npat_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          npat_q <= (num_pat == '0) ? PCW'(1) : num_pat;
          beat   <= '0;
          pat_q  <= '0;
          st     <= ST_SHIFT;
        end
        ST_SHIFT: if (stim_valid) begin
          beat <= last_beat ? '0 : beat + 1'b1;
          if (last_beat) st <= ST_CAPT;
        end
        ST_CAPT: begin
          pat_q <= pat_q + 1'b1;
          st    <= (PCW'(pat_q + 1'b1) == npat_q) ? ST_FLUSH : ST_SHIFT;
        end
        ST_FLUSH: begin
          beat <= last_beat ? '0 : beat + 1'b1;
          if (last_beat) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_tog_stats.sv
module scan_tog_stats
  import scan_tog_pkg::*;
#(
  parameter int TOGW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            act,
  input  logic [TOGW-1:0] tog,
  input  logic [TOGW-1:0] budget,
  output logic [31:0]     total,
  output logic [TOGW-1:0] peak,
  output logic            over,
  output logic [31:0]     over_idx
);
  logic [31:0] step_cnt;
  logic        breach;

  assign breach = act && exceeds(int'(tog), int'(budget));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total    <= '0;
      peak     <= '0;
      over     <= 1'b0;
      over_idx <= '0;
      step_cnt <= '0;
    end else if (clr) begin
      total    <= '0;
      peak     <= '0;
      over     <= 1'b0;
      over_idx <= '0;
      step_cnt <= '0;
    end else if (act) begin
      total    <= total + 32'(tog);
      step_cnt <= step_cnt + 1'b1;
      if (tog > peak) peak <= tog;
      if (breach && !over) begin
        over     <= 1'b1;
        over_idx <= step_cnt;
      end
    end
  end
endmodule

// File: rtl/scan_tog_seq.sv
module scan_tog_seq
  import scan_tog_pkg::*;
#(
  parameter int NCH = 3,
  parameter logic [NCH*8-1:0] LENS = 24'h03_06_04,
  parameter int PCW = 8,
  localparam int MAXL = max_len(LENS),
  localparam int TOGW = $clog2(NCH*MAXL + 1),
  localparam int BW   = $clog2(MAXL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PCW-1:0]  num_pat,
  input  logic [TOGW-1:0] budget,
  input  logic            stim_valid,
  output logic            stim_ready,
  input  logic [NCH-1:0]  stim_bits,
  input  logic [NCH-1:0]  resp_bits,
  output logic            busy,
  output logic            done,
  output logic [TOGW-1:0] step_tog,
  output logic [31:0]     tog_total,
  output logic [TOGW-1:0] tog_peak,
  output logic            over_budget,
  output logic [31:0]     over_idx
);
  function automatic int max_len(input logic [NCH*8-1:0] v);
    int m;
    m = 0;
    for (int k = 0; k < NCH; k++)
      if (int'(v[k*8 +: 8]) > m) m = int'(v[k*8 +: 8]);
    return m;
  endfunction

  logic          shift_w, capt_w, from_w, start_w, act_w;
  logic [BW-1:0] beat_w;
  logic [TOGW-1:0] raw_tog;

  assign act_w    = shift_w | capt_w;
  assign step_tog = act_w ? raw_tog : '0;

  scan_seq_ctrl #(.MAXL(MAXL), .PCW(PCW), .BW(BW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .num_pat(num_pat),
    .stim_valid(stim_valid), .stim_ready(stim_ready),
    .shift_en(shift_w), .capt_en(capt_w), .from_stream(from_w),
    .beat(beat_w), .start_acc(start_w), .busy(busy), .done(done)
  );

  scan_chain_bank #(.NCH(NCH), .LENS(LENS), .MAXL(MAXL), .TOGW(TOGW), .BW(BW)) bank_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_w), .capt_en(capt_w),
    .from_stream(from_w), .beat(beat_w), .stim_bits(stim_bits),
    .resp_bits(resp_bits), .tog(raw_tog)
  );

  scan_tog_stats #(.TOGW(TOGW)) stats_i (
    .clk(clk), .rst_n(rst_n), .clr(start_w), .act(act_w), .tog(step_tog),
    .budget(budget), .total(tog_total), .peak(tog_peak),
    .over(over_budget), .over_idx(over_idx)
  );
endmodule

// File: rtl/scan_tog_chk.sv
module scan_tog_chk #(
  parameter int TOGW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            stim_valid,
  input logic            stim_ready,
  input logic            capt_w,
  input logic [TOGW-1:0] step_tog,
  input logic [TOGW-1:0] budget,
  input logic [31:0]     tog_total,
  input logic [TOGW-1:0] tog_peak,
  input logic            over_budget
);
  // R1
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stim_ready |-> busy);
  // R1
  single_capt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capt_w |=> !capt_w);
  // R6
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_ready && !stim_valid) |-> step_tog == '0);
  // R7
  total_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> tog_total == $past(tog_total) + 32'($past(step_tog)));
  // R7
  peak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> tog_peak >= $past(step_tog));
  // R8
  over_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_tog > budget) |=> over_budget);
  // R8
  over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over_budget && !start) |=> over_budget);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind scan_tog_seq scan_tog_chk #(.TOGW(TOGW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .stim_valid(stim_valid), .stim_ready(stim_ready), .capt_w(capt_w),
  .step_tog(step_tog), .budget(budget), .tog_total(tog_total),
  .tog_peak(tog_peak), .over_budget(over_budget)
);

// File: tb/scan_tog_seq_tb.sv
module scan_tog_seq_tb_top;
  localparam int NCH = 3;
  localparam int L   = 6;
  localparam int TW  = 5;
  localparam int LEN [NCH] = '{4, 6, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] num_pat = '0;
  logic [TW-1:0] budget = '0;
  logic stim_valid = 1'b0;
  logic stim_ready;
  logic [NCH-1:0] stim_bits = '0, resp_bits = '0;
  logic busy, done, over_budget;
  logic [TW-1:0] step_tog, tog_peak;
  logic [31:0] tog_total, over_idx;

  int vectors = 0, miscompares = 0;
  int mch [NCH][L];
  int sv [NCH][L];
  int rv [NCH][L];
  int ins [NCH];
  int m_total, m_peak, m_over, m_idx, m_step, m_bud;

  always #5 clk = ~clk;

  scan_tog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .num_pat(num_pat), .budget(budget),
    .stim_valid(stim_valid), .stim_ready(stim_ready), .stim_bits(stim_bits),
    .resp_bits(resp_bits), .busy(busy), .done(done), .step_tog(step_tog),
    .tog_total(tog_total), .tog_peak(tog_peak), .over_budget(over_budget),
    .over_idx(over_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // Behavioural chain shift; returns flip-flop changes.
  function automatic int model_shift();
    int t;
    t = 0;
    for (int k = 0; k < NCH; k++) begin
      for (int i = LEN[k] - 1; i >= 1; i--) begin
        if (mch[k][i] != mch[k][i-1]) t++;
        mch[k][i] = mch[k][i-1];
      end
      if (mch[k][0] != ins[k]) t++;
      mch[k][0] = ins[k];
    end
    return t;
  endfunction

  task automatic model_step(input int t);
    m_total += t;
    if (t > m_peak) m_peak = t;
    if (t > m_bud && m_over == 0) begin
      m_over = 1;
      m_idx  = m_step;
    end
    m_step++;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int np, input int bud, input int stall_every, input bit poke);
    int eff, act_cyc, t;
    logic [NCH-1:0] sb, rb;
    eff = (np == 0) ? 1 : np;
    m_total = 0; m_peak = 0; m_over = 0; m_idx = 0; m_step = 0; m_bud = bud;
    act_cyc = 0;
    budget = TW'(bud);
    num_pat = 8'(np);
    start = 1'b1;
    tick();
    start = 1'b0;
    // R7 R8: statistics cleared by the accepted start
    chk("R7 total cleared", int'(tog_total), 0);
    chk("R7 peak cleared", int'(tog_peak), 0);
    chk("R8 flag cleared", int'(over_budget), 0);
    for (int p = 0; p < eff; p++) begin
      for (int k = 0; k < NCH; k++)
        for (int i = 0; i < L; i++) begin
          sv[k][i] = int'($urandom_range(1, 0));
          rv[k][i] = int'($urandom_range(1, 0));
        end
      for (int j = 0; j < L; j++) begin
        if (stall_every != 0 && (j % stall_every) == 1) begin
          stim_valid = 1'b0;
          stim_bits = NCH'($urandom);
          #1;
          chk("R6 stall toggles", int'(step_tog), 0);
          chk("R1 ready in stall", int'(stim_ready), 1);
          tick();
        end
        if (poke && p == 0 && j == 2) begin
          start = 1'b1;
          num_pat = 8'd9;
        end
        for (int k = 0; k < NCH; k++) begin
          int off;
          off = L - LEN[k];
          if (j >= off) begin
            sb[k] = sv[k][LEN[k]-1-(j-off)][0];
            rb[k] = rv[k][LEN[k]-1-(j-off)][0];
            ins[k] = sv[k][LEN[k]-1-(j-off)];
          end else begin
            sb[k] = 1'($urandom);
            rb[k] = 1'($urandom);
            ins[k] = 0;
          end
        end
        stim_valid = 1'b1;
        stim_bits = sb;
        resp_bits = rb;
        #1;
        t = model_shift();
        // R2 R3 R4: shift toggle count with filler masking
        chk("R4 shift toggles", int'(step_tog), t);
        chk("R1 ready in shift", int'(stim_ready), 1);
        model_step(t);
        act_cyc++;
        tick();
        start = 1'b0;
        num_pat = 8'(np);
      end
      stim_valid = 1'b0;
      #1;
      t = 0;
      for (int k = 0; k < NCH; k++)
        for (int i = 0; i < LEN[k]; i++) begin
          if (mch[k][i] != rv[k][i]) t++;
          mch[k][i] = rv[k][i];
        end
      chk("R5 capture toggles", int'(step_tog), t);
      chk("R1 ready low in capture", int'(stim_ready), 0);
      model_step(t);
      act_cyc++;
      tick();
    end
    for (int j = 0; j < L; j++) begin
      for (int k = 0; k < NCH; k++) ins[k] = 0;
      #1;
      t = model_shift();
      chk("R4 unload toggles", int'(step_tog), t);
      chk("R1 ready low in unload", int'(stim_ready), 0);
      model_step(t);
      act_cyc++;
      tick();
    end
    chk("R9 done pulse", int'(done), 1);
    chk("R9 busy low at done", int'(busy), 0);
    chk("R1 active cycles", act_cyc, (L + 1) * eff + L);
    chk("R7 total", int'(tog_total), m_total);
    chk("R7 peak", int'(tog_peak), m_peak);
    chk("R8 flag", int'(over_budget), m_over);
    if (m_over != 0) chk("R8 first index", int'(over_idx), m_idx);
    tick();
    chk("R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog: got timeout expected run completion");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < NCH; k++)
      for (int i = 0; i < L; i++) mch[k][i] = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 ready", int'(stim_ready), 0);
    chk("R10 step_tog", int'(step_tog), 0);
    chk("R10 total", int'(tog_total), 0);
    chk("R10 flag", int'(over_budget), 0);
    rst_n = 1'b1;
    tick();
    chk("R10 done", int'(done), 0);
    chk("R10 peak", int'(tog_peak), 0);
    run(3, 31, 0, 1'b0);
    run(2, 3, 3, 1'b1);
    repeat (3) tick();
    // R8: sticky while idle
    chk("R8 sticky in idle", int'(over_budget), m_over);
    run(0, 0, 0, 1'b0);
    run(4, 6, 2, 1'b0);
    summary();
    $finish;
  end
endmodule